// File: doc/BRIEF.md
# Pin Control Register Bank

The block holds one 32-bit configuration word for each of 32 package pins and exposes it on a simple synchronous register bus. The bus has a read strobe, a write strobe, a word address and 32-bit write and read data. The decoded settings of every pin leave the block as flat vectors, one bit or one field per pin, ready for the pad ring. Those settings are pull enable and direction, slew rate, passive filter, open drain, drive strength, function select and a 4-bit event-configuration field.

Each pin word has a sticky lock bit. Once the lock bit is set, the lower half of that word is frozen until reset. Two broadcast addresses let a single bus write load the same lower-half value into any chosen subset of pins. One address serves the bottom half of the pins and the other serves the top half. The subset is given as a mask in the upper half of the write data. Locked pins are passed over by these broadcast writes.

Top module: `pin_ctrl_bank`

## Requirements
- R1: After reset every pin word is zero, so every output vector is zero and the function select of every pin is 0 (disabled/analog); read data is zero.
- R2: Word bits [1:0] are the pull code. 2'b10 gives pull_en=1 and pull_up=0 (pull-down). 2'b11 gives pull_en=1 and pull_up=1. Codes 2'b00 and 2'b01 give no pull.
- R3: Word bit 2 drives slew_slow, bit 4 pfilt_en, bit 5 odrain_en and bit 6 drive_hi. Bits [10:8] are the 3-bit function select on mux_o[3i+:3], where 0 means disabled/analog, 1 means GPIO and 2–7 select alternates. Bits [19:16] appear on evt_cfg_o[4i+:4].
- R4: Pin word i sits at word address i (0–31). A read returns the full word, with bits 3, 7, 14:11 and 31:20 reading as zero. The read data appears on the clock edge that samples rd_i and holds until the next read.
- R5: Bit 15 is a lock. While it is set, writes to bits [15:0] of that word are ignored until reset, but bits [19:16] stay writable by a direct write.
- R6: A write to address 32 is a broadcast to pins 0–15. Data bit 16+i selects pin i, and every selected pin loads data [15:0] into word bits [15:0]. Unselected pins and bits [31:16] of all words are unchanged.
- R7: A write to address 33 is a broadcast to pins 16–31. Data bit 16+k selects pin 16+k. All other behaviour follows R6.
- R8: Broadcast writes leave locked pins unchanged.
- R9: Addresses 32–63 read as zero. Writes to addresses 34–63 change nothing.
- R10: When a read and a write to the same pin word fall in the same cycle, the read returns the value from before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rd_i | input | 1 | Read strobe |
| wr_i | input | 1 | Write strobe |
| addr_i | input | 6 | Word address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Registered read data |
| pull_en_o | output | 32 | Pull resistor enabled, per pin |
| pull_up_o | output | 32 | Pull direction up, per pin |
| slew_slow_o | output | 32 | Slow slew selected, per pin |
| pfilt_en_o | output | 32 | Passive filter enabled, per pin |
| odrain_en_o | output | 32 | Open drain enabled, per pin |
| drive_hi_o | output | 32 | High drive strength, per pin |
| mux_o | output | 96 | Function select, 3 bits per pin |
| evt_cfg_o | output | 128 | Event configuration, 4 bits per pin |
| lock_o | output | 32 | Lock bit, per pin |

## Verification
Two functions can act in the same cycle. The first is a read and a write aimed at the same pin word. The second is a write that sets a pin's lock together with a later broadcast write whose mask selects that pin. The bench raises both strobes in one cycle and checks that the read returns the pre-write word and that the next read shows the new one. It then locks a pin and sends a broadcast that selects both the locked pin and an unlocked neighbour. The pass criterion is that only the neighbour changes, and that a direct write still reaches the locked pin's upper field.

// File: rtl/pcb_pkg.sv
package pcb_pkg;
  localparam int unsigned REG_W   = 32;
  localparam int unsigned HALF_W  = 16;
  localparam int unsigned MUX_W   = 3;
  localparam int unsigned EVT_W   = 4;

  localparam int unsigned B_PULL_LSB = 0;
  localparam int unsigned B_PULL_MSB = 1;
  localparam int unsigned B_SLEW     = 2;
  localparam int unsigned B_PFILT    = 4;
  localparam int unsigned B_ODRAIN   = 5;
  localparam int unsigned B_DRIVE    = 6;
  localparam int unsigned B_MUX      = 8;
  localparam int unsigned B_LOCK     = 15;
  localparam int unsigned B_EVT      = 16;

  // implemented bits of each half
  localparam logic [HALF_W-1:0] LO_MASK = 16'h8777;
  localparam logic [HALF_W-1:0] HI_MASK = 16'h000F;
endpackage

// File: rtl/pcb_decode.sv
module pcb_decode #(
  parameter int unsigned N_PINS = 32,
  parameter int unsigned AW     = 6,
  localparam int unsigned HALF  = N_PINS / 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [AW-1:0]     addr_i,
  input  logic [HALF-1:0]   mask_i,
  output logic [N_PINS-1:0] pin_wr_o,
  output logic [N_PINS-1:0] bcast_o
);
  logic sel_lo, sel_hi;
  assign sel_lo = wr_i && (addr_i == AW'(N_PINS));
  assign sel_hi = wr_i && (addr_i == AW'(N_PINS + 1));

  for (genvar i = 0; i < N_PINS; i++) begin : g_pin
    assign pin_wr_o[i] = wr_i && (addr_i == AW'(i));
    if (i < HALF) begin : g_lo
      assign bcast_o[i] = sel_lo && mask_i[i];
    end else begin : g_hi
      assign bcast_o[i] = sel_hi && mask_i[i-HALF];
    end
  end

  AST_ONE_DIRECT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(pin_wr_o)); // R4
  AST_BCAST_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|bcast_o) |-> !(|pin_wr_o)); // R6
  AST_BCAST_HALF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !((|bcast_o[HALF-1:0]) && (|bcast_o[N_PINS-1:HALF]))); // R7
endmodule

// File: rtl/pcb_pin_reg.sv
module pcb_pin_reg
  import pcb_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_full_i,
  input  logic             wr_bcast_i,
  input  logic [REG_W-1:0] wdata_i,
  output logic [REG_W-1:0] q_o
);
  logic [HALF_W-1:0] q_lo, q_hi;
  logic              locked, lo_we;

  assign locked = q_lo[B_LOCK];
  assign lo_we  = (wr_full_i || wr_bcast_i) && !locked;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      q_lo <= '0;
      q_hi <= '0;
    end else begin
      if (lo_we)     q_lo <= wdata_i[HALF_W-1:0] & LO_MASK;
      if (wr_full_i) q_hi <= wdata_i[REG_W-1:HALF_W] & HI_MASK;
    end
  end

  assign q_o = {q_hi, q_lo};

  AST_LOCK_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    q_o[B_LOCK] |=> $stable(q_o[HALF_W-1:0])); // R5
  AST_BCAST_UPPER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_bcast_i && !wr_full_i) |=> $stable(q_o[REG_W-1:HALF_W])); // R6
  AST_LOCK_BCAST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_bcast_i && q_o[B_LOCK]) |=> $stable(q_o)); // R8
endmodule

// File: rtl/pcb_rdmux.sv
module pcb_rdmux
  import pcb_pkg::*;
#(
  parameter int unsigned N_PINS = 32,
  parameter int unsigned AW     = 6,
  localparam int unsigned PIN_W = $clog2(N_PINS)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             rd_i,
  input  logic [AW-1:0]    addr_i,
  input  logic [REG_W-1:0] regs_i [N_PINS],
  output logic [REG_W-1:0] rdata_o
);
  logic hit;
  assign hit = addr_i < AW'(N_PINS);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   rdata_o <= '0;
    else if (rd_i) rdata_o <= hit ? regs_i[addr_i[PIN_W-1:0]] : '0;
  end

  AST_RD_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_i |=> $stable(rdata_o)); // R4
  AST_RD_UNMAPPED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && !hit) |=> (rdata_o == '0)); // R9
endmodule

// File: rtl/pin_ctrl_bank.sv
module pin_ctrl_bank
  import pcb_pkg::*;
#(
  parameter int unsigned N_PINS = 32,
  localparam int unsigned AW    = $clog2(N_PINS) + 1,
  localparam int unsigned HALF  = N_PINS / 2
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    rd_i,
  input  logic                    wr_i,
  input  logic [AW-1:0]           addr_i,
  input  logic [REG_W-1:0]        wdata_i,
  output logic [REG_W-1:0]        rdata_o,
  output logic [N_PINS-1:0]       pull_en_o,
  output logic [N_PINS-1:0]       pull_up_o,
  output logic [N_PINS-1:0]       slew_slow_o,
  output logic [N_PINS-1:0]       pfilt_en_o,
  output logic [N_PINS-1:0]       odrain_en_o,
  output logic [N_PINS-1:0]       drive_hi_o,
  output logic [N_PINS*MUX_W-1:0] mux_o,
  output logic [N_PINS*EVT_W-1:0] evt_cfg_o,
  output logic [N_PINS-1:0]       lock_o
);
  logic [N_PINS-1:0] pin_wr, bcast;
  logic [REG_W-1:0]  regs [N_PINS];

  pcb_decode #(.N_PINS(N_PINS), .AW(AW)) i_decode (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_i     (wr_i),
    .addr_i   (addr_i),
    .mask_i   (wdata_i[HALF_W +: HALF]),
    .pin_wr_o (pin_wr),
    .bcast_o  (bcast)
  );

  for (genvar i = 0; i < N_PINS; i++) begin : g_pin
    pcb_pin_reg i_reg (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .wr_full_i  (pin_wr[i]),
      .wr_bcast_i (bcast[i]),
      .wdata_i    (wdata_i),
      .q_o        (regs[i])
    );
    assign pull_en_o[i]   = regs[i][B_PULL_MSB];
    assign pull_up_o[i]   = regs[i][B_PULL_MSB] & regs[i][B_PULL_LSB];
    assign slew_slow_o[i] = regs[i][B_SLEW];
    assign pfilt_en_o[i]  = regs[i][B_PFILT];
    assign odrain_en_o[i] = regs[i][B_ODRAIN];
    assign drive_hi_o[i]  = regs[i][B_DRIVE];
    assign mux_o[i*MUX_W +: MUX_W]   = regs[i][B_MUX +: MUX_W];
    assign evt_cfg_o[i*EVT_W +: EVT_W] = regs[i][B_EVT +: EVT_W];
    assign lock_o[i]      = regs[i][B_LOCK];
  end

  pcb_rdmux #(.N_PINS(N_PINS), .AW(AW)) i_rdmux (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .rd_i    (rd_i),
    .addr_i  (addr_i),
    .regs_i  (regs),
    .rdata_o (rdata_o)
  );

  AST_PULLUP_NEEDS_EN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pull_up_o & ~pull_en_o) == '0); // R2
endmodule

// File: tb/test_pin_ctrl_bank.sv
`timescale 1ns/1ps
module test_pin_ctrl_bank;
  localparam int N = 32;
  localparam int NV = 15;

  logic clk_i = 1'b0, rst_ni = 1'b0, rd_i = 1'b0, wr_i = 1'b0;
  logic [5:0]   addr_i = '0;
  logic [31:0]  wdata_i = '0;
  logic [31:0]  rdata_o;
  logic [N-1:0] pull_en_o, pull_up_o, slew_slow_o, pfilt_en_o, odrain_en_o, drive_hi_o, lock_o;
  logic [N*3-1:0] mux_o;
  logic [N*4-1:0] evt_cfg_o;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #2 clk_i = ~clk_i;

  pin_ctrl_bank i_pin_ctrl_bank (
    .clk_i, .rst_ni, .rd_i, .wr_i, .addr_i, .wdata_i, .rdata_o,
    .pull_en_o, .pull_up_o, .slew_slow_o, .pfilt_en_o, .odrain_en_o,
    .drive_hi_o, .mux_o, .evt_cfg_o, .lock_o
  );

  // {write addr, write data, read addr, expected read, requirement}
  localparam logic [79:0] VEC [NV] = '{
    {6'd0,  32'h0003_7FFF, 6'd0,  32'h0003_0777, 4'd4},  // R4 reserved bits drop
    {6'd1,  32'h0000_0002, 6'd1,  32'h0000_0002, 4'd2},  // R2
    {6'd32, 32'h0006_0045, 6'd2,  32'h0000_0045, 4'd6},  // R6 pins 1,2
    {6'd40, 32'hFFFF_FFFF, 6'd1,  32'h0000_0045, 4'd6},  // R6 pin 1 also loaded
    {6'd40, 32'hFFFF_FFFF, 6'd0,  32'h0003_0777, 4'd9},  // R9 unmapped write, pin 0 unselected
    {6'd33, 32'h8000_0101, 6'd31, 32'h0000_0101, 4'd7},  // R7 pin 31
    {6'd63, 32'h0000_0000, 6'd16, 32'h0000_0000, 4'd7},  // R7 pin 16 unselected
    {6'd63, 32'h0000_0000, 6'd33, 32'h0000_0000, 4'd9},  // R9 broadcast reads zero
    {6'd5,  32'h0000_8301, 6'd5,  32'h0000_8301, 4'd5},  // R5 lock set
    {6'd5,  32'h000A_0000, 6'd5,  32'h000A_8301, 4'd5},  // R5 upper writable
    {6'd32, 32'h0030_0044, 6'd5,  32'h000A_8301, 4'd8},  // R8 locked pin skipped
    {6'd63, 32'h0000_0000, 6'd4,  32'h0000_0044, 4'd8},  // R8 neighbour loaded
    {6'd1,  32'h0005_0000, 6'd1,  32'h0005_0000, 4'd6},  // R6 setup upper
    {6'd32, 32'h0002_0070, 6'd1,  32'h0005_0070, 4'd6},  // R6 upper kept
    {6'd5,  32'h0000_0000, 6'd5,  32'h0000_8301, 4'd5}   // R5 lower frozen
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic do_write(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk_i);
    wr_i = 1'b1; addr_i = a; wdata_i = d;
    @(negedge clk_i);
    wr_i = 1'b0;
  endtask

  task automatic do_read(input logic [5:0] a, output logic [31:0] d);
    @(negedge clk_i);
    rd_i = 1'b1; addr_i = a;
    @(negedge clk_i);
    rd_i = 1'b0;
    d = rdata_o;
  endtask

  initial begin
    logic [31:0] rv;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    // R1 reset state
    chk("R1 rdata", rdata_o, 32'h0);
    chk("R1 pull_en", pull_en_o, 32'h0);
    chk("R1 lock", lock_o, 32'h0);
    chk("R1 mux low", mux_o[31:0], 32'h0);
    chk("R1 mux high", mux_o[95:64], 32'h0);
    chk("R1 evt", evt_cfg_o[31:0], 32'h0);

    for (int v = 0; v < NV; v++) begin
      do_write(VEC[v][79:74], VEC[v][73:42]);
      do_read(VEC[v][41:36], rv);
      chk($sformatf("R%0d vector %0d", VEC[v][3:0], v), rv, VEC[v][35:4]);
    end

    // R3 decoded outputs
    chk("R3 slew", slew_slow_o, 32'h0000_0015);
    chk("R3 pfilt", pfilt_en_o, 32'h0000_0003);
    chk("R3 odrain", odrain_en_o, 32'h0000_0003);
    chk("R3 drive", drive_hi_o, 32'h0000_0017);
    chk("R3 mux pin0", 32'(mux_o[0 +: 3]), 32'd7);
    chk("R3 mux pin5", 32'(mux_o[15 +: 3]), 32'd3);
    chk("R3 mux pin31 gpio", 32'(mux_o[93 +: 3]), 32'd1);
    chk("R3 evt pin0", 32'(evt_cfg_o[0 +: 4]), 32'd3);
    chk("R3 evt pin1", 32'(evt_cfg_o[4 +: 4]), 32'd5);
    chk("R5 lock vector", lock_o, 32'h0000_0020);
    // R2 pull decode: code 01 on pins 2,5,31 gives no pull
    chk("R2 pull_en", pull_en_o, 32'h0000_0001);
    chk("R2 pull_up", pull_up_o, 32'h0000_0001);
    do_write(6'd6, 32'h0000_0002);
    chk("R2 pulldown en", pull_en_o, 32'h0000_0041);
    chk("R2 pulldown dir", pull_up_o, 32'h0000_0001);

    // R10 same-cycle read and write
    @(negedge clk_i);
    rd_i = 1'b1; wr_i = 1'b1; addr_i = 6'd6; wdata_i = 32'h0000_0003;
    @(negedge clk_i);
    rd_i = 1'b0; wr_i = 1'b0;
    chk("R10 old value", rdata_o, 32'h0000_0002);
    do_read(6'd6, rv);
    chk("R10 new value", rv, 32'h0000_0003);
    chk("R2 pullup", pull_up_o, 32'h0000_0041);
    // R4 hold between reads
    do_write(6'd6, 32'h0000_0000);
    repeat (3) @(negedge clk_i);
    chk("R4 rdata held", rdata_o, 32'h0000_0003);

    // R5 lock released only by reset; R1 clears words
    rst_ni = 1'b0;
    repeat (2) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk("R1 lock after reset", lock_o, 32'h0);
    chk("R1 rdata after reset", rdata_o, 32'h0);
    do_read(6'd5, rv);
    chk("R1 pin5 cleared", rv, 32'h0);
    do_write(6'd5, 32'h0000_0001);
    do_read(6'd5, rv);
    chk("R5 writable after reset", rv, 32'h0000_0001);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog (all) actual=hang expected=done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule